// File: doc/BRIEF.md
# Sum-of-Products MAC Sequencer

This block is a small hardware loop engine that forms the dot product of two signed 16-bit vectors held in a data memory. A single start pulse supplies a coefficient base address, a sample base address, a result address and a term count. The engine then walks both vectors through its own post-incremented halfword pointers. It multiplies each coefficient by its paired sample and adds the product to a 32-bit running sum. When the term counter has reached zero, it writes the sum back to memory as one word and pulses done.

Operands come through one synchronous memory port. Read data appears on the cycle after the read strobe, so every term costs four cycles: coefficient fetch, sample fetch, multiply, add. A loop counter is loaded with the count. It drops by one in the multiply step of each term, and the add step goes round again only while the counter is non-zero. A count of zero issues no reads at all and stores zero.

Top module: `sop_engine`

## Requirements
- R1: After a job, exactly one 32-bit word is written on the memory port. Its address is the result address given with the accepted start, and its value is the sum over k = 0..count-1 of coef[k]*samp[k].
- R2: The loop counter takes the count at start and drops by one per term; a job of count N issues exactly 2*N halfword reads.
- R3: Reads alternate, coefficient first and then sample. For term k the coefficient address is coef_base + 2k and the sample address is samp_base + 2k. A read and a write never happen in the same cycle.
- R4: Data on mem_rd_data is taken on the cycle after the read strobe that requested it (one-cycle read latency).
- R5: A count of zero performs no read and stores the value 0.
- R6: Operands and products are two's-complement signed (16x16 gives 32 bits); the sum wraps modulo 2^32 with no saturation.
- R7: done is high for exactly one cycle, the cycle right after the store cycle.
- R8: A start pulse while busy is high has no effect: the running job keeps its addresses and count, and only one store occurs.
- R9: During and after reset, busy, done, mem_rd_en and mem_wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a job; taken only while idle |
| count | input | CNT_W | Number of product terms |
| coef_base | input | ADDR_W | Byte address of the first coefficient halfword |
| samp_base | input | ADDR_W | Byte address of the first sample halfword |
| res_addr | input | ADDR_W | Byte address that receives the 32-bit result |
| mem_rd_data | input | DATA_W | Halfword returned one cycle after mem_rd_en |
| mem_rd_en | output | 1 | Halfword read strobe |
| mem_wr_en | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W | Byte address for the current read or write |
| mem_wr_data | output | ACC_W | Result word to store |
| busy | output | 1 | High from the cycle after an accepted start until the job returns to idle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that the memory answers every read strobe with data exactly one cycle later, and that ACC_W is at least twice DATA_W. They also assume the result address is never a read address during a job. The bench memory model is a registered array that honours that latency. All chosen bases and counts keep both operand windows inside it, and results go to a separate region. Start pulses are driven between clock edges as single-cycle pulses, including one placed deliberately while a job is in flight.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_FETCH_X,
        ST_MUL,
        ST_ADD,
        ST_STORE,
        ST_DONE
    } seq_state_t;

    // byte distance between consecutive halfword operands
    localparam int unsigned HALF_BYTES = 2;

    // control strobes from the sequencer to the arithmetic path
    typedef struct packed {
        logic clear;
        logic ld_coef;
        logic mul;
        logic add;
    } mac_ctl_t;

    function automatic logic is_fetch(input seq_state_t s);
        return (s == ST_FETCH_A) || (s == ST_FETCH_X);
    endfunction

endpackage

// File: rtl/sop_ctrl.sv
module sop_ctrl
    import sop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] coef_base,
    input  logic [ADDR_W-1:0] samp_base,
    input  logic [ADDR_W-1:0] res_addr,
    output mac_ctl_t          mac_ctl,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(HALF_BYTES);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    seq_state_t        state;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] a_ptr;
    logic [ADDR_W-1:0] x_ptr;
    logic [ADDR_W-1:0] y_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt_q <= '0;
            a_ptr <= '0;
            x_ptr <= '0;
            y_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q <= count;
                        a_ptr <= coef_base;
                        x_ptr <= samp_base;
                        y_q   <= res_addr;
                        state <= (count == '0) ? ST_STORE : ST_FETCH_A;
                    end
                end
                ST_FETCH_A: begin
                    a_ptr <= a_ptr + STEP;
                    state <= ST_FETCH_X;
                end
                ST_FETCH_X: begin
                    x_ptr <= x_ptr + STEP;
                    state <= ST_MUL;
                end
                ST_MUL: begin
                    cnt_q <= cnt_q - ONE;
                    state <= ST_ADD;
                end
                ST_ADD: begin
                    // continuation predicated on a non-zero counter
                    state <= (cnt_q != '0) ? ST_FETCH_A : ST_STORE;
                end
                ST_STORE: state <= ST_DONE;
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd_en = is_fetch(state);
        mem_wr_en = (state == ST_STORE);
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        case (state)
            ST_FETCH_A: mem_addr = a_ptr;
            ST_FETCH_X: mem_addr = x_ptr;
            ST_STORE:   mem_addr = y_q;
            default:    mem_addr = '0;
        endcase
        mac_ctl.clear   = (state == ST_IDLE) && start;
        mac_ctl.ld_coef = (state == ST_FETCH_X);
        mac_ctl.mul     = (state == ST_MUL);
        mac_ctl.add     = (state == ST_ADD);
    end

    assert_cnt_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MUL) |=> (cnt_q == $past(cnt_q) - ONE));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_A) |=> (a_ptr == $past(a_ptr) + STEP));

    assert_rw_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    assert_zero_skip_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && count == '0) |=> (mem_wr_en && !mem_rd_en));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_store_done_R7: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> done);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(y_q));

endmodule

// File: rtl/sop_mac.sv
module sop_mac
    import sop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  mac_ctl_t          ctl,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ACC_W-1:0]  acc
);

    localparam int PROD_W = 2 * DATA_W;

    logic        [DATA_W-1:0] coef_q;
    logic signed [PROD_W-1:0] prod_full;
    logic        [PROD_W-1:0] prod_q;
    logic        [ACC_W-1:0]  prod_ext;
    logic        [ACC_W-1:0]  acc_q;

    assign prod_full = PROD_W'($signed(coef_q)) * PROD_W'($signed(rd_data));

    generate
        if (ACC_W > PROD_W) begin : g_sext
            assign prod_ext = {{(ACC_W - PROD_W){prod_q[PROD_W-1]}}, prod_q};
        end else begin : g_trunc
            assign prod_ext = prod_q[ACC_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_q <= '0;
            prod_q <= '0;
            acc_q  <= '0;
        end else begin
            if (ctl.clear)   acc_q  <= '0;
            if (ctl.ld_coef) coef_q <= rd_data;
            if (ctl.mul)     prod_q <= prod_full;
            if (ctl.add)     acc_q  <= acc_q + prod_ext;
        end
    end

    assign acc = acc_q;

    assert_clear_add_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(ctl.clear && ctl.add));

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> (acc_q == '0));

    assert_coef_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.mul |=> $stable(coef_q));

endmodule

// File: rtl/sop_engine.sv
module sop_engine
    import sop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] coef_base,
    input  logic [ADDR_W-1:0] samp_base,
    input  logic [ADDR_W-1:0] res_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ACC_W-1:0]  mem_wr_data,
    output logic              busy,
    output logic              done
);

    mac_ctl_t mac_ctl;

    sop_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .count     (count),
        .coef_base (coef_base),
        .samp_base (samp_base),
        .res_addr  (res_addr),
        .mac_ctl   (mac_ctl),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .done      (done)
    );

    sop_mac #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk     (clk),
        .rst     (rst),
        .ctl     (mac_ctl),
        .rd_data (mem_rd_data),
        .acc     (mem_wr_data)
    );

    assert_store_stable_R1: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> $stable(mem_wr_data));

endmodule

// File: tb/sim_sop_engine.sv
`timescale 1ns/1ps
module sim_sop_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  count;
    logic [15:0] coef_base, samp_base, res_addr;
    logic [15:0] mem_rd_data;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_addr;
    logic [31:0] mem_wr_data;
    logic        busy, done;

    always #5 clk = ~clk;

    sop_engine u0 (
        .clk(clk), .rst(rst), .start(start), .count(count),
        .coef_base(coef_base), .samp_base(samp_base), .res_addr(res_addr),
        .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wr_data(mem_wr_data), .busy(busy), .done(done)
    );

    logic [15:0] mem [512];
    int checks = 0;
    int errors = 0;

    // memory model: one-cycle read latency
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_addr[9:1]];
    end

    // port monitor, sampled between edges
    int cyc = 0;
    int rd_total = 0, rd_bad = 0, wr_total = 0;
    int job_rd = 0;
    int cur_a = 0, cur_x = 0;
    int bad_act = 0, bad_exp = 0;
    int wr_cyc = 0;
    logic [15:0] wr_addr_cap;
    logic [31:0] wr_data_cap;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!busy) job_rd = 0;
        if (mem_rd_en) begin
            int exp_a;
            exp_a = ((job_rd % 2) == 0) ? cur_a + job_rd : cur_x + job_rd - 1;
            if (int'(mem_addr) != exp_a) begin
                rd_bad++;
                bad_act = int'(mem_addr);
                bad_exp = exp_a;
            end
            job_rd++;
            rd_total++;
        end
        if (mem_wr_en) begin
            wr_total++;
            wr_addr_cap = mem_addr;
            wr_data_cap = mem_wr_data;
            wr_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int exp_sum(input int a_b, input int x_b, input int n);
        int s = 0;
        for (int k = 0; k < n; k++) begin
            shortint ca, sx;
            ca = shortint'(mem[(a_b >> 1) + k]);
            sx = shortint'(mem[(x_b >> 1) + k]);
            s += int'(ca) * int'(sx);
        end
        return s;
    endfunction

    task automatic pulse_start(input int a_b, input int x_b, input int y_b, input int n);
        @(negedge clk);
        coef_base = 16'(a_b);
        samp_base = 16'(x_b);
        res_addr  = 16'(y_b);
        count     = 8'(n);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    // waits for done; returns 1 if seen
    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_job(input int a_b, input int x_b, input int y_b, input int n,
                           input int spoil_after);
        int rd0, bad0, wr0, expv, done_cyc;
        bit seen;
        rd0 = rd_total; bad0 = rd_bad; wr0 = wr_total;
        expv = exp_sum(a_b, x_b, n);
        cur_a = a_b; cur_x = x_b;
        pulse_start(a_b, x_b, y_b, n);
        if (spoil_after > 0) begin
            repeat (spoil_after) @(negedge clk);
            // R8: start while busy must be ignored
            pulse_start(a_b + 64, x_b + 64, 16'h03F0, 2);
        end
        wait_done(seen);
        done_cyc = cyc;
        check(seen, "R7", "done seen", seen, 1);
        check(wr_total - wr0 == 1, "R1", "store count", wr_total - wr0, 1);
        check(wr_addr_cap == 16'(y_b), "R1", "store address", wr_addr_cap, y_b);
        check(wr_data_cap == 32'(expv), "R1/R4/R6", "result", wr_data_cap, 32'(expv));
        check(rd_total - rd0 == 2 * n, "R2", "read count", rd_total - rd0, 2 * n);
        check(rd_bad == bad0, "R3", "read address order", bad_act, bad_exp);
        check(done_cyc == wr_cyc + 1, "R7", "done one cycle after store", done_cyc, wr_cyc + 1);
        if (n == 0)
            check(wr_data_cap == 32'h0 && rd_total == rd0, "R5", "zero count", wr_data_cap, 0);
        @(negedge clk);
        check(!done, "R7", "done single cycle", done, 0);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; count = '0;
        coef_base = '0; samp_base = '0; res_addr = '0;
        for (int i = 0; i < 512; i++) mem[i] = 16'(i * 37 - 3000);
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd_en && !mem_wr_en, "R9", "outputs in reset",
              {busy, done, mem_rd_en, mem_wr_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_rd_en && !mem_wr_en, "R9", "idle after reset",
              {busy, done, mem_rd_en, mem_wr_en}, 0);

        // sweep of term counts 0..40 over a ramp
        for (int n = 0; n <= 40; n++) run_job(16'h0000, 16'h0100, 16'h0300 + 4 * n, n, 0);

        // scrambled operands at other bases
        for (int i = 0; i < 512; i++) mem[i] = 16'((i * 40503) ^ (i << 9) ^ 16'h5A3C);
        run_job(16'h0040, 16'h0180, 16'h0340, 40, 0);
        run_job(16'h0002, 16'h0002, 16'h0344, 17, 0);
        run_job(16'h0010, 16'h01F0, 16'h0348, 1, 0);

        // R6: wrap with extreme negative operands
        for (int i = 0; i < 512; i++) mem[i] = 16'h8000;
        run_job(16'h0000, 16'h0100, 16'h0350, 3, 0);
        check(wr_data_cap == 32'hC000_0000, "R6", "3 x 2^30 wraps", wr_data_cap, 32'hC000_0000);
        run_job(16'h0000, 16'h0100, 16'h0354, 4, 0);
        check(wr_data_cap == 32'h0, "R6", "4 x 2^30 wraps to zero", wr_data_cap, 0);
        for (int i = 0; i < 512; i++) mem[i] = ((i % 2) == 0) ? 16'h7FFF : 16'h8000;
        run_job(16'h0000, 16'h0100, 16'h0358, 40, 0);

        // R8: start during a running job
        for (int i = 0; i < 512; i++) mem[i] = 16'(i * 5 - 700);
        run_job(16'h0020, 16'h0120, 16'h0360, 10, 5);
        check(wr_addr_cap == 16'h0360, "R8", "ignored start kept address", wr_addr_cap, 16'h0360);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule